// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block is the host-side serial master for a dual-channel 8-bit DAC. A client offers one command through a valid/ready handshake. The command is made of a reference-source flag, an update-both-outputs flag, two per-channel sleep flags, a channel select, a two-bit load operation and an 8-bit output code. The block packs these into a 16-bit word and shifts it out on a three-wire link: a serial clock, a serial data line and an active-low frame strobe.

The serial clock is made from the system clock by a half-period divider. The divider value is programmable, and the block raises it to a floor that keeps the serial clock at or below 30 MHz. A build-time parameter selects one of two framings. The first is a continuous 16-clock burst. The second sends the word as two 8-clock bytes, with the serial clock held low for a programmable number of extra system cycles between them while the strobe stays low. Each frame is followed by a strobe-high gap of one full serial clock period. A one-cycle pulse marks the end of each frame.

Top module: `dacfrm_tx`

## Requirements
- R1: The 16-bit word is laid out as follows: bit 15 is the reference flag, bit 14 is always 0, bit 13 is the update-both flag, bit 12 is the channel-B sleep flag, bit 11 is the channel-A sleep flag, bit 10 is the channel select, bits 9:8 are the load operation and bits 7:0 are the code. The word is sent most significant bit first, as exactly 16 rising edges of `ser_clk` per frame.
- R2: `ser_clk` idles low and is high only while `frame_n` is low. `ser_dat` changes only while `ser_clk` is low and holds steady through every high phase.
- R3: With H = max(`half_div`, 4) at the default 200 MHz / 30 MHz settings, every high phase and every ordinary low phase of `ser_clk` lasts exactly H system cycles.
- R4: `frame_n` falls in the cycle after a word is accepted. The first rising edge of `ser_clk` comes H cycles later. `frame_n` rises H cycles after the last falling edge, so a continuous frame holds `frame_n` low for 33·H cycles.
- R5: In the two-byte variant, the low phase between bit 8 and bit 9 lasts H + `byte_pause` cycles with `frame_n` kept low. The continuous variant ignores `byte_pause`.
- R6: Between back-to-back frames, `frame_n` stays high for exactly 2·H + 1 cycles, which is one full serial clock period plus the accept cycle.
- R7: `in_ready` is high only while no frame or gap is in progress, and it falls in the cycle after an acceptance. While it is low, the command fields, `in_valid`, `half_div` and `byte_pause` have no effect. The divider, pause and command fields are captured at acceptance.
- R8: `done` is high for exactly one cycle: the first cycle in which `frame_n` is high again.
- R9: During and right after reset, `frame_n` is 1, `ser_clk` is 0, `ser_dat` is 0, `in_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Block can accept a command |
| in_ref_ext | input | 1 | Reference-source flag (bit 15) |
| in_upd_all | input | 1 | Update-both-outputs flag (bit 13) |
| in_pd_b | input | 1 | Channel-B sleep flag (bit 12) |
| in_pd_a | input | 1 | Channel-A sleep flag (bit 11) |
| in_sel_b | input | 1 | Channel select (bit 10) |
| in_op | input | 2 | Load operation (bits 9:8) |
| in_code | input | 8 | Output code (bits 7:0) |
| half_div | input | DIV_W | Requested serial half period in system cycles |
| byte_pause | input | PAUSE_W | Extra low cycles between bytes (two-byte variant) |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dat | output | 1 | Serial data, MSB first |
| frame_n | output | 1 | Active-low frame strobe |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can fall in the same cycle: the end of the strobe-high gap, where `in_ready` returns, and a new acceptance when `in_valid` is held high. The same holds for the frame end, where `frame_n` rises and `done` pulses together. The bench holds `in_valid` high across two frames and changes the fields right after the first acceptance. It then judges the measured strobe-high run against 2·H + 1 and checks that the second frame carries the new word. A monitor flags any cycle in which `done` and a rising `frame_n` disagree. Both variants are swept over every divider value from 0 to 7 and several pause lengths.

// File: rtl/dacfrm_pkg.sv
package dacfrm_pkg;

    localparam int CODE_W   = 8;
    localparam int CTRL_W   = 8;
    localparam int WORD_W   = CTRL_W + CODE_W;
    localparam int SPLIT_AT = CTRL_W;   // rising edges sent before the inter-byte pause

    typedef struct packed {
        logic              ref_ext;
        logic              upd_all;
        logic              pd_b;
        logic              pd_a;
        logic              sel_b;
        logic [1:0]        op;
        logic [CODE_W-1:0] code;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_PAUSE,
        ST_HOLD,
        ST_GAP
    } st_t;

    // Control byte first, spare position forced to zero.
    function automatic logic [WORD_W-1:0] pack_word(input cmd_t c);
        return {c.ref_ext, 1'b0, c.upd_all, c.pd_b, c.pd_a, c.sel_b, c.op, c.code};
    endfunction

    // Smallest half period (system cycles) keeping the serial clock at or below the limit.
    function automatic int min_half(input int sys_mhz, input int max_mhz);
        int period;
        period = (sys_mhz + max_mhz - 1) / max_mhz;
        return (period + 1) / 2;
    endfunction

endpackage

// File: rtl/dacfrm_timer.sv
module dacfrm_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dacfrm_shift.sv
module dacfrm_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= word;
        end else if (shift) begin
            q <= {q[W-2:0], 1'b0};
        end
    end

    assign msb = q[W-1];
endmodule

// File: rtl/dacfrm_ctrl.sv
module dacfrm_ctrl
    import dacfrm_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int PAUSE_W  = 6,
    parameter int TMR_W    = 7,
    parameter int MIN_HALF = 4,
    parameter bit TWO_BYTE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [PAUSE_W-1:0] byte_pause,
    input  logic               expired,
    output logic               ready,
    output logic               tmr_load,
    output logic [TMR_W-1:0]   tmr_len,
    output logic               word_load,
    output logic               bit_shift,
    output logic               sclk_o,
    output logic               frame_n_o,
    output logic               done_q
);
    localparam int BC_W = $clog2(WORD_W + 1);
    localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

    st_t                st, st_n;
    logic [DIV_W-1:0]   h_q;
    logic [PAUSE_W-1:0] p_q;
    logic [BC_W-1:0]    bits_q, bits_n, bits_inc;
    logic [DIV_W-1:0]   h_in;
    logic               accept, last_bit, pause_here, done_n;

    assign ready    = (st == ST_IDLE);
    assign accept   = ready && in_valid;
    assign h_in     = (half_div < MIN_H) ? MIN_H : half_div;
    assign bits_inc = bits_q + BC_W'(1);
    assign last_bit = (bits_inc == BC_W'(WORD_W));

    generate
        if (TWO_BYTE) begin : g_split
            assign pause_here = (bits_inc == BC_W'(SPLIT_AT)) && (p_q != '0);
        end else begin : g_cont
            assign pause_here = 1'b0;
        end
    endgenerate

    always_comb begin
        st_n      = st;
        bits_n    = bits_q;
        tmr_load  = 1'b0;
        tmr_len   = TMR_W'(h_q);
        word_load = 1'b0;
        bit_shift = 1'b0;
        done_n    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (in_valid) begin
                    st_n      = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_len   = TMR_W'(h_in);
                    word_load = 1'b1;
                    bits_n    = '0;
                end
            end
            ST_SETUP: begin
                if (expired) begin
                    st_n     = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expired) begin
                    bit_shift = 1'b1;
                    bits_n    = bits_inc;
                    tmr_load  = 1'b1;
                    if (last_bit) begin
                        st_n = ST_HOLD;
                    end else if (pause_here) begin
                        st_n    = ST_PAUSE;
                        tmr_len = TMR_W'(p_q);
                    end else begin
                        st_n = ST_LOW;
                    end
                end
            end
            ST_LOW: begin
                if (expired) begin
                    st_n     = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (expired) begin
                    st_n     = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (expired) begin
                    st_n     = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'({h_q, 1'b0});
                    done_n   = 1'b1;
                end
            end
            ST_GAP: begin
                if (expired) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bits_q <= '0;
            h_q    <= MIN_H;
            p_q    <= '0;
            done_q <= 1'b0;
        end else begin
            st     <= st_n;
            bits_q <= bits_n;
            done_q <= done_n;
            if (accept) begin
                h_q <= h_in;
                p_q <= byte_pause;
            end
        end
    end

    assign sclk_o    = (st == ST_HIGH);
    assign frame_n_o = !(st inside {ST_SETUP, ST_HIGH, ST_LOW, ST_PAUSE, ST_HOLD});
endmodule

// File: rtl/dacfrm_tx.sv
module dacfrm_tx
    import dacfrm_pkg::*;
#(
    parameter int SYS_MHZ      = 200,
    parameter int SCLK_MAX_MHZ = 30,
    parameter int DIV_W        = 6,
    parameter int PAUSE_W      = 6,
    parameter bit TWO_BYTE     = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_ref_ext,
    input  logic               in_upd_all,
    input  logic               in_pd_b,
    input  logic               in_pd_a,
    input  logic               in_sel_b,
    input  logic [1:0]         in_op,
    input  logic [7:0]         in_code,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [PAUSE_W-1:0] byte_pause,
    output logic               ser_clk,
    output logic               ser_dat,
    output logic               frame_n,
    output logic               done
);
    localparam int MIN_HALF = min_half(SYS_MHZ, SCLK_MAX_MHZ);
    localparam int TMR_W    = (DIV_W + 1 > PAUSE_W) ? DIV_W + 1 : PAUSE_W;

    cmd_t              cmd;
    logic [WORD_W-1:0] word;
    logic              tmr_load, expired, word_load, bit_shift, msb, frame_n_i;
    logic [TMR_W-1:0]  tmr_len;

    assign cmd = '{ref_ext: in_ref_ext, upd_all: in_upd_all, pd_b: in_pd_b,
                   pd_a: in_pd_a, sel_b: in_sel_b, op: in_op, code: in_code};
    assign word = pack_word(cmd);

    dacfrm_ctrl #(
        .DIV_W    (DIV_W),
        .PAUSE_W  (PAUSE_W),
        .TMR_W    (TMR_W),
        .MIN_HALF (MIN_HALF),
        .TWO_BYTE (TWO_BYTE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .half_div   (half_div),
        .byte_pause (byte_pause),
        .expired    (expired),
        .ready      (in_ready),
        .tmr_load   (tmr_load),
        .tmr_len    (tmr_len),
        .word_load  (word_load),
        .bit_shift  (bit_shift),
        .sclk_o     (ser_clk),
        .frame_n_o  (frame_n_i),
        .done_q     (done)
    );

    dacfrm_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (expired)
    );

    dacfrm_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (word_load),
        .word  (word),
        .shift (bit_shift),
        .msb   (msb)
    );

    assign frame_n = frame_n_i;
    assign ser_dat = !frame_n_i && msb;
endmodule

// File: rtl/dacfrm_tx_chk.sv
module dacfrm_tx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic ser_clk,
    input logic ser_dat,
    input logic frame_n,
    input logic done
);
    assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !frame_n);

    assert_dat_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    assert_fall_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |-> $past(in_valid && in_ready));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_idle_strobe_high_R7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> frame_n);

    assert_done_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_n && !$past(frame_n)));

    assert_rise_gives_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> done);
endmodule

bind dacfrm_tx dacfrm_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .frame_n  (frame_n),
    .done     (done)
);

// File: tb/dacfrm_tx_test.sv
`timescale 1ns/1ps

module dacfrm_mon (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic dat,
    input logic fn,
    input logic done
);
    logic [15:0] word;
    int nrise, flen, setup, mid, hold, hi_min, hi_max, lo_min, lo_max, gap, frames;
    int v_clk, v_done, run, hcnt;
    logic psclk, pfn, pdat;

    always @(negedge clk) begin
        if (rst) begin
            word = '0; nrise = 0; flen = 0; setup = 0; mid = 0; hold = 0;
            hi_min = 1 << 20; hi_max = 0; lo_min = 1 << 20; lo_max = 0;
            gap = 0; frames = 0; v_clk = 0; v_done = 0; run = 0; hcnt = 0;
            psclk = 1'b0; pfn = 1'b1; pdat = 1'b0;
        end else begin
            if (done !== (fn && !pfn)) v_done++;
            if (sclk && fn) v_clk++;
            if (sclk && psclk && (dat !== pdat)) v_clk++;
            if (!fn) begin
                if (pfn) begin
                    gap = hcnt; word = '0; nrise = 0; flen = 0; run = 1;
                    hi_min = 1 << 20; hi_max = 0; lo_min = 1 << 20; lo_max = 0;
                end else if (sclk != psclk) begin
                    if (psclk) begin
                        if (run < hi_min) hi_min = run;
                        if (run > hi_max) hi_max = run;
                    end else if (nrise == 0) setup = run;
                    else if (nrise == 8) mid = run;
                    else begin
                        if (run < lo_min) lo_min = run;
                        if (run > lo_max) lo_max = run;
                    end
                    run = 1;
                end else begin
                    run++;
                end
                flen++;
                if (sclk && !psclk) begin
                    word = {word[14:0], dat};
                    nrise++;
                end
            end else begin
                if (!pfn) begin
                    hold = run; frames++; hcnt = 1;
                end else begin
                    hcnt++;
                end
            end
            psclk = sclk; pfn = fn; pdat = dat;
        end
    end
endmodule

module dacfrm_tx_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld_s = 1'b0, vld_c = 1'b0;
    logic f_ref = 0, f_upd = 0, f_pdb = 0, f_pda = 0, f_sel = 0;
    logic [1:0] f_op = '0;
    logic [7:0] f_code = '0;
    logic [5:0] half_div = '0, byte_pause = '0;
    logic rdy_s, rdy_c, sclk_s, sclk_c, dat_s, dat_c, fn_s, fn_c, done_s, done_c;
    int nerr = 0, nchk = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dacfrm_tx #(.TWO_BYTE(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(vld_s), .in_ready(rdy_s),
        .in_ref_ext(f_ref), .in_upd_all(f_upd), .in_pd_b(f_pdb), .in_pd_a(f_pda),
        .in_sel_b(f_sel), .in_op(f_op), .in_code(f_code),
        .half_div(half_div), .byte_pause(byte_pause),
        .ser_clk(sclk_s), .ser_dat(dat_s), .frame_n(fn_s), .done(done_s));

    dacfrm_tx #(.TWO_BYTE(1'b0)) uut_c (
        .clk(clk), .rst(rst), .in_valid(vld_c), .in_ready(rdy_c),
        .in_ref_ext(f_ref), .in_upd_all(f_upd), .in_pd_b(f_pdb), .in_pd_a(f_pda),
        .in_sel_b(f_sel), .in_op(f_op), .in_code(f_code),
        .half_div(half_div), .byte_pause(byte_pause),
        .ser_clk(sclk_c), .ser_dat(dat_c), .frame_n(fn_c), .done(done_c));

    dacfrm_mon mon_s (.clk(clk), .rst(rst), .sclk(sclk_s), .dat(dat_s), .fn(fn_s), .done(done_s));
    dacfrm_mon mon_c (.clk(clk), .rst(rst), .sclk(sclk_c), .dat(dat_c), .fn(fn_c), .done(done_c));

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic set_fields(input logic [15:0] v);
        f_ref = v[15]; f_upd = v[13]; f_pdb = v[12]; f_pda = v[11];
        f_sel = v[10]; f_op = v[9:8]; f_code = v[7:0];
    endtask

    function automatic int exp_word;
        return int'(f_ref) * 32768 + int'(f_upd) * 8192 + int'(f_pdb) * 4096 +
               int'(f_pda) * 2048 + int'(f_sel) * 1024 + int'(f_op) * 256 + int'(f_code);
    endfunction

    function automatic int eff_half(input int h);
        return (h < 4) ? 4 : h;
    endfunction

    function automatic int frames_of(input bit two);
        return two ? mon_s.frames : mon_c.frames;
    endfunction

    // Offer the current fields to one instance and wait until accepted.
    task automatic offer(input bit two);
        if (two) vld_s = 1'b1; else vld_c = 1'b1;
        tick();
        while (!(two ? rdy_s : rdy_c)) tick();
        tick();
        vld_s = 1'b0; vld_c = 1'b0;
        chk("R7 ready low after accept", int'(two ? rdy_s : rdy_c), 0);
    endtask

    task automatic wait_frame(input bit two, input int f0);
        while (frames_of(two) == f0) tick();
    endtask

    task automatic do_frame(input bit two, input logic [15:0] v, input int half, input int pause);
        int f0, h, ew, extra;
        set_fields(v);
        half_div = 6'(half);
        byte_pause = 6'(pause);
        ew = exp_word();
        h = eff_half(half);
        extra = two ? pause : 0;
        f0 = frames_of(two);
        offer(two);
        wait_frame(two, f0);
        if (two) begin
            chk("R1 word", int'(mon_s.word), ew);
            chk("R1 edges", mon_s.nrise, 16);
            chk("R3 high min", mon_s.hi_min, h);
            chk("R3 high max", mon_s.hi_max, h);
            chk("R3 low min", mon_s.lo_min, h);
            chk("R3 low max", mon_s.lo_max, h);
            chk("R4 setup", mon_s.setup, h);
            chk("R4 hold", mon_s.hold, h);
            chk("R4 frame length", mon_s.flen, 33 * h + extra);
            chk("R5 byte pause", mon_s.mid, h + extra);
            chk("R2 clock/data rules", mon_s.v_clk, 0);
            chk("R8 done pulse", mon_s.v_done, 0);
        end else begin
            chk("R1 word", int'(mon_c.word), ew);
            chk("R1 edges", mon_c.nrise, 16);
            chk("R3 high max", mon_c.hi_max, h);
            chk("R3 low max", mon_c.lo_max, h);
            chk("R4 setup", mon_c.setup, h);
            chk("R4 frame length", mon_c.flen, 33 * h);
            chk("R5 pause ignored", mon_c.mid, h);
            chk("R2 clock/data rules", mon_c.v_clk, 0);
            chk("R8 done pulse", mon_c.v_done, 0);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int f0, w1, w2;
        // R9: reset state
        repeat (3) tick();
        chk("R9 frame_n in reset", int'(fn_s), 1);
        chk("R9 ready in reset", int'(rdy_s), 1);
        rst = 1'b0;
        tick();
        chk("R9 frame_n", int'(fn_s), 1);
        chk("R9 ser_clk", int'(sclk_s), 0);
        chk("R9 ser_dat", int'(dat_s), 0);
        chk("R9 ready", int'(rdy_s), 1);
        chk("R9 done", int'(done_s), 0);

        // R3 R4 R5: divider and pause sweep, both variants
        for (int h = 0; h < 8; h++) begin
            for (int p = 0; p < 3; p++) begin
                int pz;
                pz = (p == 0) ? 0 : (p == 1) ? 2 : 5;
                do_frame(1'b1, 16'((h * 4099 + pz * 613 + 16'h35A7) & 16'hBFFF), h, pz);
                do_frame(1'b0, 16'((h * 7919 + pz * 211 + 16'h5C3B) & 16'hBFFF), h, pz);
            end
        end

        // R1: walk every field bit, then all ones
        for (int i = 0; i < 16; i++) begin
            do_frame(1'b1, 16'(1 << i), 0, 1);
        end
        do_frame(1'b1, 16'hFFFF, 0, 0);
        chk("R1 spare bit sent as zero", int'(mon_s.word), 16'hBFFF);

        // R6 R7: back-to-back frames with valid held high
        set_fields(16'h9A5C);
        w1 = exp_word();
        half_div = 6'd5;
        byte_pause = 6'd0;
        f0 = mon_s.frames;
        vld_s = 1'b1;
        tick();
        while (!rdy_s) tick();
        tick();
        set_fields(16'h2BC3);
        w2 = exp_word();
        chk("R7 ready low after accept", int'(rdy_s), 0);
        wait_frame(1'b1, f0);
        chk("R7 first word captured", int'(mon_s.word), w1);
        while (!rdy_s) tick();
        tick();
        vld_s = 1'b0;
        wait_frame(1'b1, f0 + 1);
        chk("R6 gap between frames", mon_s.gap, 2 * 5 + 1);
        chk("R7 second word", int'(mon_s.word), w2);

        // R7: inputs ignored while busy
        set_fields(16'h1234);
        w1 = exp_word();
        half_div = 6'd4;
        f0 = mon_s.frames;
        offer(1'b1);
        set_fields(16'hA0FF);
        half_div = 6'd7;
        byte_pause = 6'd9;
        vld_s = 1'b1;
        repeat (10) tick();
        chk("R7 still busy", int'(rdy_s), 0);
        vld_s = 1'b0;
        wait_frame(1'b1, f0);
        repeat (40) tick();
        chk("R7 no extra frame", mon_s.frames, f0 + 1);
        chk("R7 word unchanged", int'(mon_s.word), w1);
        chk("R7 divider captured", mon_s.hi_max, 4);
        chk("R7 pause captured", mon_s.mid, 4);
        chk("R8 done pulses", mon_s.v_done, 0);
        chk("R8 done pulses continuous", mon_c.v_done, 0);
        chk("R2 final", mon_s.v_clk + mon_c.v_clk, 0);
        finish_run();
    end
endmodule